// File: doc/BRIEF.md
# Line-Doubled Scan Address Generator

This block sits between a 640x480 video timing generator and a byte-wide video RAM. It turns the timing generator's active flag, dot column and scan line into RAM read addresses for a 320x240 picture of one byte per pixel. Each stored pixel covers two dot clocks and each stored line is shown on two consecutive scan lines, so a quarter-size image fills the whole 640x480 raster.

Memory is laid out with a fixed 512-byte stride per stored line. Only the first 320 bytes of a stride are ever read for video; the upper 192 bytes of every stride remain free for other use. The address is the stored line index in the upper bits and the stored column index in the lower nine bits, which makes the address formation a pure bit concatenation.

The block issues a fetch strobe on each even dot column of visible video, latches the byte the RAM returns and holds it for two dot clocks, and drives a 6-bit colour (two bits per primary) that is forced to zero whenever the raster position is not visible. A small scan state machine with three states, S_BLANK, S_FETCH and S_HOLD, tracks the phase: S_BLANK to S_FETCH on a visible even column, S_FETCH to S_HOLD on a visible odd column, S_HOLD to S_FETCH on the next visible even column, and any state to S_BLANK on a non-visible cycle or an end-of-line pulse.

Top module: `vscan_top`

## Requirements
- R1: One clock after a cycle that issues a fetch, `ram_addr` equals (scan_line >> 1) * 512 + (dot_col >> 1).
- R2: Scan lines 2k and 2k+1 produce identical address sequences for the same columns, so each stored line appears twice.
- R3: `fetch_stb` is high exactly one clock after a cycle in which `vid_active` is 1, `dot_col` is even and below 640, `scan_line` is below 480 and `line_end` is 0; otherwise it is low.
- R4: Whenever `fetch_stb` is high, the low nine bits of `ram_addr` are below 320.
- R5: The RAM returns the addressed byte on `ram_rdata` one clock after the strobe; three clocks after a visible cycle, `rgb_out` equals bits 5:0 of the most recently fetched byte (bits 5:4 red, 3:2 green, 1:0 blue), bits 7:6 being ignored, so each fetched byte is shown for two dot clocks.
- R6: Three clocks after any cycle that is not visible (vid_active low, column at or above 640, or line at or above 480), `rgb_out` is zero.
- R7: While `rst_n` is low, `fetch_stb`, `ram_addr` and `rgb_out` are all zero.
- R8: `ram_addr` keeps its value on every clock in which `fetch_stb` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vid_active | input | 1 | Timing generator active-video flag |
| dot_col | input | 10 | Current dot column |
| scan_line | input | 9 | Current scan line |
| line_end | input | 1 | End-of-line pulse from the timing generator |
| ram_rdata | input | 8 | Byte returned by the RAM one clock after a strobe |
| ram_addr | output | 17 | Video RAM read address |
| fetch_stb | output | 1 | Read request, one clock wide per stored pixel |
| rgb_out | output | 6 | Colour, two bits per primary, zero when not visible |

## Verification
Full visible lines are scanned at even and odd scan line numbers, including the first and last stored lines, so the doubled address sequence and the top address bits are both exercised. A line whose active window opens on an odd column shows whether the odd phase wrongly fetches or leaks a stale byte, and a line with the active flag held past column 640 and a line numbered 480 separate the range guards from the active flag. An end-of-line pulse in mid-line shows that the pulse suppresses one fetch, and a RAM pattern whose top bits differ from the colour bits shows that bits 7:6 never reach the colour.

// File: rtl/vscan_pkg.sv
package vscan_pkg;

    // Phase of the scan: no visible pixel, fetch cycle, or hold cycle.
    typedef enum logic [1:0] {
        S_BLANK = 2'd0,
        S_FETCH = 2'd1,
        S_HOLD  = 2'd2
    } scan_state_t;

    // Colour layout inside a pixel byte.
    localparam int RED_HI = 5;
    localparam int GRN_HI = 3;
    localparam int BLU_HI = 1;

endpackage

// File: rtl/vscan_pipe.sv
module vscan_pipe #(
    parameter int DEPTH = 3,
    parameter int W     = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stage [DEPTH+1];

    always_comb stage[0] = din;

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage[i+1] <= '0;
            end else begin
                stage[i+1] <= stage[i];
            end
        end
    end

    assign dout = stage[DEPTH];

endmodule

// File: rtl/vscan_addr.sv
module vscan_addr
    import vscan_pkg::*;
#(
    parameter int COL_W     = 10,
    parameter int LINE_W    = 9,
    parameter int PAGE_BITS = 9,
    parameter int H_ACTIVE  = 640,
    parameter int V_ACTIVE  = 480,
    localparam int ADDR_W   = LINE_W - 1 + PAGE_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vid_active,
    input  logic [COL_W-1:0]  dot_col,
    input  logic [LINE_W-1:0] scan_line,
    input  logic              line_end,
    output logic              visible,
    output logic              fetch_stb,
    output logic [ADDR_W-1:0] ram_addr
);

    scan_state_t state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic              in_range;
    logic              even_col;
    logic              take_fetch;

    // Range guards keep a misprogrammed timing source from reading
    // the free part of a page or lines past the frame.
    always_comb begin
        in_range   = (dot_col < COL_W'(H_ACTIVE)) && (scan_line < LINE_W'(V_ACTIVE));
        visible    = vid_active && in_range;
        even_col   = !dot_col[0];
        take_fetch = visible && even_col && !line_end;
    end

    // Next-state selection.
    always_comb begin
        state_d = S_BLANK;
        unique case (state_q)
            S_BLANK: begin
                if (take_fetch)               state_d = S_FETCH;
                else if (visible && !line_end) state_d = S_HOLD;
                else                          state_d = S_BLANK;
            end
            S_FETCH: begin
                if (take_fetch)               state_d = S_FETCH;
                else if (visible && !line_end) state_d = S_HOLD;
                else                          state_d = S_BLANK;
            end
            S_HOLD: begin
                if (take_fetch)               state_d = S_FETCH;
                else if (visible && !line_end) state_d = S_HOLD;
                else                          state_d = S_BLANK;
            end
            default: state_d = S_BLANK;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_BLANK;
        end else begin
            state_q <= state_d;
        end
    end

    // Address register: stored line in the upper bits, stored column
    // in the page offset; loaded only on a fetch, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (take_fetch) begin
            addr_q <= {scan_line[LINE_W-1:1], PAGE_BITS'(dot_col[COL_W-1:1])};
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        fetch_stb = 1'b0;
        unique case (state_q)
            S_BLANK: fetch_stb = 1'b0;
            S_FETCH: fetch_stb = 1'b1;
            S_HOLD:  fetch_stb = 1'b0;
            default: fetch_stb = 1'b0;
        endcase
        ram_addr = addr_q;
    end

endmodule

// File: rtl/vscan_pix.sv
module vscan_pix #(
    parameter int PIX_W = 8,
    parameter int RGB_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_ok,
    input  logic [PIX_W-1:0] ram_rdata,
    input  logic             show,
    output logic [RGB_W-1:0] rgb_out
);

    logic [RGB_W-1:0] pix_q;

    // Only the colour bits are kept; the upper byte bits are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_q <= '0;
        end else if (data_ok) begin
            pix_q <= ram_rdata[RGB_W-1:0];
        end
    end

    assign rgb_out = show ? pix_q : '0;

endmodule

// File: rtl/vscan_top.sv
module vscan_top #(
    parameter int COL_W     = 10,
    parameter int LINE_W    = 9,
    parameter int PAGE_BITS = 9,
    parameter int H_ACTIVE  = 640,
    parameter int V_ACTIVE  = 480,
    parameter int PIX_W     = 8,
    parameter int RGB_W     = 6,
    parameter int RAM_LAT   = 1,
    localparam int ADDR_W   = LINE_W - 1 + PAGE_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vid_active,
    input  logic [COL_W-1:0]  dot_col,
    input  logic [LINE_W-1:0] scan_line,
    input  logic              line_end,
    input  logic [PIX_W-1:0]  ram_rdata,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              fetch_stb,
    output logic [RGB_W-1:0]  rgb_out
);

    // Address register, RAM latency, then the pixel latch.
    localparam int SHOW_DEPTH = RAM_LAT + 2;

    logic visible;
    logic data_ok;
    logic show_d;

    vscan_addr #(
        .COL_W     (COL_W),
        .LINE_W    (LINE_W),
        .PAGE_BITS (PAGE_BITS),
        .H_ACTIVE  (H_ACTIVE),
        .V_ACTIVE  (V_ACTIVE)
    ) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .vid_active (vid_active),
        .dot_col    (dot_col),
        .scan_line  (scan_line),
        .line_end   (line_end),
        .visible    (visible),
        .fetch_stb  (fetch_stb),
        .ram_addr   (ram_addr)
    );

    vscan_pipe #(.DEPTH(RAM_LAT), .W(1)) u_stb_pipe (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (fetch_stb),
        .dout  (data_ok)
    );

    vscan_pipe #(.DEPTH(SHOW_DEPTH), .W(1)) u_show_pipe (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (visible),
        .dout  (show_d)
    );

    vscan_pix #(.PIX_W(PIX_W), .RGB_W(RGB_W)) u_pix (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_ok   (data_ok),
        .ram_rdata (ram_rdata),
        .show      (show_d),
        .rgb_out   (rgb_out)
    );

endmodule

// File: rtl/vscan_chk.sv
module vscan_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        vid_active,
    input logic [9:0]  dot_col,
    input logic [8:0]  scan_line,
    input logic        line_end,
    input logic [16:0] ram_addr,
    input logic        fetch_stb,
    input logic [5:0]  rgb_out
);

    logic [1:0] since_rst;
    logic       vis_in;

    always_ff @(posedge clk) begin
        if (!rst_n) since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    assign vis_in = vid_active && (dot_col < 10'd640) && (scan_line < 9'd480);

    // R1: address follows the inputs of the previous cycle
    assert_addr_form_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0 && fetch_stb) |->
            ram_addr == {$past(scan_line[8:1]), $past(dot_col[9:1])});

    // R3: a strobe only follows an even visible column without line end
    assert_stb_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0 && fetch_stb) |->
            ($past(vis_in) && !$past(dot_col[0]) && !$past(line_end)));

    // R4: strobed offsets stay inside the shown part of a page
    assert_page_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_stb |-> (ram_addr[8:0] < 9'd320));

    // R6: colour is dark three cycles after a non-visible cycle
    assert_dark_blank_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && !$past(vis_in, 3)) |-> (rgb_out == 6'd0));

    // R8: address holds between strobes
    assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0 && !fetch_stb) |-> $stable(ram_addr));

    // R7: outputs are quiet while reset is held
    always @(negedge clk) begin
        if (!rst_n && since_rst == 2'd0 && $past(!rst_n)) begin
            assert_reset_quiet_R7: assert (!fetch_stb && rgb_out == 6'd0 && ram_addr == 17'd0);
        end
    end

endmodule

bind vscan_top vscan_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .vid_active (vid_active),
    .dot_col    (dot_col),
    .scan_line  (scan_line),
    .line_end   (line_end),
    .ram_addr   (ram_addr),
    .fetch_stb  (fetch_stb),
    .rgb_out    (rgb_out)
);

// File: tb/vscan_top_tb.sv
`timescale 1ns/100ps
module vscan_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vid_active = 1'b0;
    logic [9:0]  dot_col = '0;
    logic [8:0]  scan_line = '0;
    logic        line_end = 1'b0;
    logic [7:0]  ram_rdata = '0;
    logic [16:0] ram_addr;
    logic        fetch_stb;
    logic [5:0]  rgb_out;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    bit stb_q[$];
    int addr_q[$];
    int rgb_q[$];
    int last_fetch = -1;
    int prev_addr = 0;
    int cap_even = -1;
    int cap_odd = -1;
    int cur_line = 0;

    always #2.5 clk = ~clk;

    vscan_top u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .vid_active (vid_active),
        .dot_col    (dot_col),
        .scan_line  (scan_line),
        .line_end   (line_end),
        .ram_rdata  (ram_rdata),
        .ram_addr   (ram_addr),
        .fetch_stb  (fetch_stb),
        .rgb_out    (rgb_out)
    );

    // RAM content is a function of the address; top bits vary too.
    function automatic logic [7:0] mem_f(input int a);
        logic [16:0] v;
        v = a[16:0];
        return (v[7:0] ^ v[16:9]) + {v[8], 7'h35};
    endfunction

    always @(posedge clk) begin
        if (fetch_stb) ram_rdata <= mem_f(int'(ram_addr));
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One dot clock: check outputs due now, then drive the next inputs.
    task automatic step(input bit act, input int col, input int line, input bit le);
        bit vis;
        bit fet;
        int a;
        @(negedge clk);
        if (stb_q.size() == 1) begin
            bit es;
            int ea;
            es = stb_q.pop_front();
            ea = addr_q.pop_front();
            chk(fetch_stb == es, "R3 strobe", int'(fetch_stb), int'(es));
            if (es) begin
                chk(int'(ram_addr) == ea, "R1 R4 address", int'(ram_addr), ea);
                if (cur_line == 100 && cap_even < 0) cap_even = int'(ram_addr);
                if (cur_line == 101 && cap_odd < 0) cap_odd = int'(ram_addr);
            end else begin
                chk(int'(ram_addr) == prev_addr, "R8 hold", int'(ram_addr), prev_addr);
            end
            prev_addr = int'(ram_addr);
        end
        if (rgb_q.size() == 3) begin
            int er;
            er = rgb_q.pop_front();
            chk(int'(rgb_out) == er, "R5 R6 colour", int'(rgb_out), er);
        end
        vis = act && col < 640 && line < 480;
        fet = vis && (col % 2 == 0) && !le;
        a = (line / 2) * 512 + col / 2;
        if (fet) last_fetch = a;
        stb_q.push_back(fet);
        addr_q.push_back(a);
        rgb_q.push_back(vis ? ((last_fetch < 0) ? 0 : int'(mem_f(last_fetch) & 8'h3F)) : 0);
        cur_line = line;
        vid_active = act;
        dot_col = col[9:0];
        scan_line = line[8:0];
        line_end = le;
    endtask

    // A line: active from a_lo to a_hi-1, optional mid-line end pulse.
    task automatic scan(input int line, input int a_lo, input int a_hi, input int le_col);
        for (int c = 0; c < 680; c++) begin
            step(c >= a_lo && c < a_hi, c, line, (c == 679) || (c == le_col));
        end
    endtask

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R7: reset state
        chk(fetch_stb == 1'b0, "R7 strobe", int'(fetch_stb), 0);
        chk(ram_addr == 17'd0, "R7 address", int'(ram_addr), 0);
        chk(rgb_out == 6'd0, "R7 colour", int'(rgb_out), 0);
        rst_n = 1'b1;
        scan(0, 0, 640, -1);
        scan(1, 0, 640, -1);
        scan(2, 0, 640, -1);
        scan(100, 0, 640, -1);
        scan(101, 0, 640, -1);
        scan(238, 0, 640, -1);
        scan(239, 0, 640, -1);
        scan(478, 0, 640, -1);
        scan(479, 0, 640, -1);
        scan(50, 5, 601, -1);     // odd start of active window
        scan(51, 0, 700, -1);     // active past column 640
        scan(480, 0, 640, -1);    // line beyond the frame
        scan(60, 0, 640, 300);    // mid-line end pulse
        for (int i = 0; i < 6; i++) step(1'b0, 0, 0, 1'b0);
        // R2: doubled lines start at the same address
        chk(cap_even == cap_odd && cap_even >= 0, "R2 doubling", cap_odd, cap_even);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule